// File: doc/BRIEF.md
# Cache and TLB Maintenance Command Sequencer

This block turns one maintenance request from the processor's system-control path into handshaked commands for five targets: the instruction cache, the data cache, the instruction TLB, the data TLB and the write buffer. A request comes as a single-cycle strobe. It carries a 4-bit secondary register field, a 3-bit opcode, a flag that selects the TLB group instead of the cache group, and an operand. The operand is an address or a set/way index, and it is passed on unchanged to the targets.

Commands leave on a shared command code and operand bus, with one request line per target. Each request line stays high until its target acknowledges. A clean-then-invalidate request becomes two steps in order. The second step starts only after the first is acknowledged and one cycle with no request has passed. While a request is in progress the block reports busy and ignores new strobes. An encoding it does not recognise produces a one-cycle error pulse and no command. The caches, TLBs and write buffer themselves are outside this block.

Top module: `maint_decoder`

## Requirements
- R1: In the cache group with opcode 0, CRm 7 requests instruction cache and data cache together, CRm 5 the instruction cache only, and CRm 6 the data cache only, all with command code 0 (whole target). Target bit order on req/ack is 0 icache, 1 dcache, 2 itlb, 3 dtlb, 4 write buffer.
- R2: In the cache group with opcode 1, CRm 5 requests the instruction cache and CRm 6 the data cache, with command code 1 (invalidate by address). The operand is presented on the operand output.
- R3: In the cache group with opcode 1, CRm 10 requests the data cache with code 2 (clean by address). CRm 14 issues code 2 and then code 1 to the data cache as two steps, with exactly one cycle in between when busy is high and no request is high.
- R4: In the cache group with opcode 2, CRm 10 requests the data cache with code 3 (clean by index). CRm 14 issues code 3 and then code 4 (invalidate by index) as two steps, spaced as in R3.
- R5: In the cache group, opcode 4 with CRm 10 requests the write buffer with code 0 (drain).
- R6: Cache-group opcode 4 with CRm 0 and opcode 1 with CRm 13 are accepted with no effect: no request, no busy and no error.
- R7: In the TLB group, opcode 0 with CRm 7, 5 or 6 requests both TLBs, the instruction TLB or the data TLB with code 0. Opcode 1 with CRm 5 or 6 requests the instruction TLB or the data TLB with code 1.
- R8: Any other encoding, in either group, raises err for exactly the cycle after the strobe. It issues no request and does not set busy.
- R9: A command appears on req the cycle after the strobe. Each req bit stays high, with code and operand held steady, until its own ack is sampled high. A step finishes only when every target it requested has acknowledged, in any order. Acks on lines that are not requesting are ignored.
- R10: busy is high from the cycle after an accepted command strobe until the cycle after the last acknowledge. Strobes that arrive while busy are ignored: they cause no error and do not change req, code or operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Single-cycle maintenance request strobe |
| op_is_tlb | input | 1 | 1 selects the TLB group, 0 the cache group |
| op_opc2 | input | 3 | Secondary opcode |
| op_crm | input | 4 | Secondary register field |
| op_arg | input | 32 | Address or index operand |
| tgt_ack | input | 5 | Per-target acknowledge |
| tgt_req | output | 5 | Per-target request |
| tgt_cmd | output | 3 | Command code for the requested targets |
| tgt_arg | output | 32 | Operand for the requested targets |
| busy | output | 1 | A command sequence is in progress |
| op_err | output | 1 | One-cycle pulse for an unrecognised encoding |

## Verification
Two situations are the hardest to reach from the ports. The first is a dual-target step whose two acknowledges arrive in different cycles in either order. The second is a two-step clean-then-invalidate that receives stray acks and fresh strobes during its idle gap. The bench returns acks per target after random delays. It adds random noise on ack lines that are not requesting. On random busy cycles it fires strobes with random encodings. It checks req, code and operand against a step list that it computes itself in every cycle.

// File: rtl/maint_pkg.sv
package maint_pkg;
    localparam int NTGT  = 5;
    localparam int CMD_W = 3;

    localparam int TGT_IC = 0;
    localparam int TGT_DC = 1;
    localparam int TGT_IT = 2;
    localparam int TGT_DT = 3;
    localparam int TGT_WB = 4;

    typedef enum logic [CMD_W-1:0] {
        CMD_WHOLE      = 3'd0,
        CMD_INV_ADDR   = 3'd1,
        CMD_CLEAN_ADDR = 3'd2,
        CMD_CLEAN_IDX  = 3'd3,
        CMD_INV_IDX    = 3'd4
    } cmd_e;

    typedef struct packed {
        logic            known;
        logic            noop;
        logic [NTGT-1:0] mask0;
        cmd_e            cmd0;
        logic            two;
        logic [NTGT-1:0] mask1;
        cmd_e            cmd1;
    } dec_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_GAP  = 2'd2
    } seq_state_e;
endpackage

// File: rtl/maint_decode.sv
module maint_decode
    import maint_pkg::*;
(
    input  logic       is_tlb,
    input  logic [2:0] opc,
    input  logic [3:0] crm,
    output dec_t       dec
);
    localparam logic [NTGT-1:0] M_IC = NTGT'(1) << TGT_IC;
    localparam logic [NTGT-1:0] M_DC = NTGT'(1) << TGT_DC;
    localparam logic [NTGT-1:0] M_IT = NTGT'(1) << TGT_IT;
    localparam logic [NTGT-1:0] M_DT = NTGT'(1) << TGT_DT;
    localparam logic [NTGT-1:0] M_WB = NTGT'(1) << TGT_WB;

    always_comb begin
        dec       = '0;
        dec.known = 1'b1;
        dec.cmd0  = CMD_WHOLE;
        dec.cmd1  = CMD_WHOLE;
        if (is_tlb) begin
            unique case ({opc, crm})
                {3'd0, 4'd7}: dec.mask0 = M_IT | M_DT;
                {3'd0, 4'd5}: dec.mask0 = M_IT;
                {3'd0, 4'd6}: dec.mask0 = M_DT;
                {3'd1, 4'd5}: begin dec.mask0 = M_IT; dec.cmd0 = CMD_INV_ADDR; end
                {3'd1, 4'd6}: begin dec.mask0 = M_DT; dec.cmd0 = CMD_INV_ADDR; end
                default:      dec.known = 1'b0;
            endcase
        end else begin
            unique case ({opc, crm})
                {3'd0, 4'd7}:  dec.mask0 = M_IC | M_DC;
                {3'd0, 4'd5}:  dec.mask0 = M_IC;
                {3'd0, 4'd6}:  dec.mask0 = M_DC;
                {3'd1, 4'd5}:  begin dec.mask0 = M_IC; dec.cmd0 = CMD_INV_ADDR; end
                {3'd1, 4'd6}:  begin dec.mask0 = M_DC; dec.cmd0 = CMD_INV_ADDR; end
                {3'd1, 4'd10}: begin dec.mask0 = M_DC; dec.cmd0 = CMD_CLEAN_ADDR; end
                {3'd1, 4'd14}: begin
                    dec.mask0 = M_DC; dec.cmd0 = CMD_CLEAN_ADDR;
                    dec.two   = 1'b1;
                    dec.mask1 = M_DC; dec.cmd1 = CMD_INV_ADDR;
                end
                {3'd2, 4'd10}: begin dec.mask0 = M_DC; dec.cmd0 = CMD_CLEAN_IDX; end
                {3'd2, 4'd14}: begin
                    dec.mask0 = M_DC; dec.cmd0 = CMD_CLEAN_IDX;
                    dec.two   = 1'b1;
                    dec.mask1 = M_DC; dec.cmd1 = CMD_INV_IDX;
                end
                {3'd4, 4'd10}: dec.mask0 = M_WB;
                {3'd4, 4'd0},
                {3'd1, 4'd13}: dec.noop = 1'b1;
                default:       dec.known = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/maint_seq.sv
module maint_seq
    import maint_pkg::*;
#(
    parameter int ARG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe,
    input  dec_t             dec,
    input  logic [ARG_W-1:0] arg_i,
    input  logic [NTGT-1:0]  ack_i,
    output logic [NTGT-1:0]  req_o,
    output logic [CMD_W-1:0] cmd_o,
    output logic [ARG_W-1:0] arg_o,
    output logic             busy_o,
    output logic             err_o
);
    typedef struct packed {
        seq_state_e      st;
        logic [NTGT-1:0] pend;
        cmd_e            cmd;
        logic [ARG_W-1:0] arg;
        logic            two;
        logic [NTGT-1:0] mask1;
        cmd_e            cmd1;
        logic            err;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.err = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (strobe) begin
                    if (!dec.known) begin
                        s_d.err = 1'b1;
                    end else if (!dec.noop) begin
                        s_d.st    = ST_RUN;
                        s_d.pend  = dec.mask0;
                        s_d.cmd   = dec.cmd0;
                        s_d.arg   = arg_i;
                        s_d.two   = dec.two;
                        s_d.mask1 = dec.mask1;
                        s_d.cmd1  = dec.cmd1;
                    end
                end
            end
            ST_RUN: begin
                s_d.pend = s_q.pend & ~ack_i;
                if (s_d.pend == '0) begin
                    s_d.st = s_q.two ? ST_GAP : ST_IDLE;
                end
            end
            ST_GAP: begin
                s_d.st   = ST_RUN;
                s_d.pend = s_q.mask1;
                s_d.cmd  = s_q.cmd1;
                s_d.two  = 1'b0;
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, cmd: CMD_WHOLE, cmd1: CMD_WHOLE, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign req_o  = s_q.pend;
    assign cmd_o  = s_q.cmd;
    assign arg_o  = s_q.arg;
    assign busy_o = (s_q.st != ST_IDLE);
    assign err_o  = s_q.err;

    // R9: each request line holds until its own acknowledge
    for (genvar i = 0; i < NTGT; i++) begin : g_hold
        p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (req_o[i] && !ack_i[i]) |=> req_o[i]);
    end

    // R9: code and operand steady while any request stays outstanding
    p_cmd_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((req_o & ~ack_i) != '0) |=> ($stable(cmd_o) && $stable(arg_o)));

    p_busy_covers_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o != '0) |-> busy_o);

    p_ignore_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && strobe) |=> !err_o);

    p_err_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (!busy_o && req_o == '0));

    // R3: an idle gap inside a sequence is always followed by the second step
    p_gap_then_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && req_o == '0) |=> (req_o != '0));
endmodule

// File: rtl/maint_decoder.sv
module maint_decoder
    import maint_pkg::*;
#(
    parameter int ARG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic             op_is_tlb,
    input  logic [2:0]       op_opc2,
    input  logic [3:0]       op_crm,
    input  logic [ARG_W-1:0] op_arg,
    input  logic [NTGT-1:0]  tgt_ack,
    output logic [NTGT-1:0]  tgt_req,
    output logic [CMD_W-1:0] tgt_cmd,
    output logic [ARG_W-1:0] tgt_arg,
    output logic             busy,
    output logic             op_err
);
    dec_t dec;

    maint_decode u_decode (
        .is_tlb (op_is_tlb),
        .opc    (op_opc2),
        .crm    (op_crm),
        .dec    (dec)
    );

    maint_seq #(.ARG_W(ARG_W)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (op_valid),
        .dec    (dec),
        .arg_i  (op_arg),
        .ack_i  (tgt_ack),
        .req_o  (tgt_req),
        .cmd_o  (tgt_cmd),
        .arg_o  (tgt_arg),
        .busy_o (busy),
        .err_o  (op_err)
    );
endmodule

// File: tb/tb_maint_decoder.sv
module tb_maint_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic        op_is_tlb = 1'b0;
    logic [2:0]  op_opc2 = '0;
    logic [3:0]  op_crm = '0;
    logic [31:0] op_arg = '0;
    logic [4:0]  tgt_ack = '0;
    logic [4:0]  tgt_req;
    logic [2:0]  tgt_cmd;
    logic [31:0] tgt_arg;
    logic        busy;
    logic        op_err;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    maint_decoder dut (.*);

    typedef struct {
        bit       err;
        bit       noop;
        bit [4:0] m0;
        bit [2:0] c0;
        bit       two;
        bit [4:0] m1;
        bit [2:0] c1;
    } exp_t;

    function automatic exp_t model(bit tlb, bit [2:0] o, bit [3:0] c);
        exp_t e = '{default: 0};
        if (tlb) begin
            if (o == 0 && c == 7)      e.m0 = 5'b01100;
            else if (o == 0 && c == 5) e.m0 = 5'b00100;
            else if (o == 0 && c == 6) e.m0 = 5'b01000;
            else if (o == 1 && c == 5) begin e.m0 = 5'b00100; e.c0 = 1; end
            else if (o == 1 && c == 6) begin e.m0 = 5'b01000; e.c0 = 1; end
            else e.err = 1;
        end else begin
            if (o == 0 && c == 7)       e.m0 = 5'b00011;
            else if (o == 0 && c == 5)  e.m0 = 5'b00001;
            else if (o == 0 && c == 6)  e.m0 = 5'b00010;
            else if (o == 1 && c == 5)  begin e.m0 = 5'b00001; e.c0 = 1; end
            else if (o == 1 && c == 6)  begin e.m0 = 5'b00010; e.c0 = 1; end
            else if (o == 1 && c == 10) begin e.m0 = 5'b00010; e.c0 = 2; end
            else if (o == 1 && c == 14) begin e.m0 = 5'b00010; e.c0 = 2; e.two = 1; e.m1 = 5'b00010; e.c1 = 1; end
            else if (o == 2 && c == 10) begin e.m0 = 5'b00010; e.c0 = 3; end
            else if (o == 2 && c == 14) begin e.m0 = 5'b00010; e.c0 = 3; e.two = 1; e.m1 = 5'b00010; e.c1 = 4; end
            else if (o == 4 && c == 10) e.m0 = 5'b10000;
            else if ((o == 4 && c == 0) || (o == 1 && c == 13)) e.noop = 1;
            else e.err = 1;
        end
        return e;
    endfunction

    task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic string tag_of(bit tlb, bit [2:0] o, bit [3:0] c, exp_t e);
        if (e.err) return "R8";
        if (e.noop) return "R6";
        if (tlb) return "R7";
        if (e.m0 == 5'b10000) return "R5";
        if (o == 2) return "R4";
        if (o == 1 && c != 5 && c != 6) return "R3";
        if (o == 1) return "R2";
        return "R1";
    endfunction

    // run one step handshake: expects mask m with code c on the bus
    task automatic run_step(string tg, bit [4:0] m, bit [2:0] c, bit [31:0] a);
        bit [4:0] pend = m;
        int waitc = 0;
        while (pend != 0) begin
            check(tgt_req == pend, tg, "req during step (R9)", tgt_req, pend);
            check(tgt_cmd == c && tgt_arg == a, tg, "cmd/arg held (R9)",
                  {tgt_cmd, tgt_arg}, {c, a});
            check(busy == 1'b1 && op_err == 1'b0, "R10", "busy high, no err", {busy, op_err}, 2'b10);
            waitc++;
            if (waitc > 6) tgt_ack = pend | (5'($urandom) & ~pend);
            else           tgt_ack = (5'($urandom) & pend) | (5'($urandom) & ~pend);
            op_valid  = ($urandom_range(0, 3) == 0);
            op_is_tlb = 1'($urandom);
            op_opc2   = 3'($urandom);
            op_crm    = 4'($urandom);
            op_arg    = $urandom;
            @(posedge clk);
            pend = pend & ~tgt_ack;
            @(negedge clk);
            tgt_ack  = '0;
            op_valid = 1'b0;
        end
    endtask

    task automatic do_op(bit tlb, bit [2:0] o, bit [3:0] c, bit [31:0] a);
        exp_t e = model(tlb, o, c);
        string tg = tag_of(tlb, o, c, e);
        op_valid = 1; op_is_tlb = tlb; op_opc2 = o; op_crm = c; op_arg = a;
        @(posedge clk);
        @(negedge clk);
        op_valid = 0;
        if (e.err) begin
            check(op_err == 1 && busy == 0 && tgt_req == 0, "R8", "error pulse",
                  {op_err, busy, tgt_req}, {1'b1, 1'b0, 5'b0});
            @(negedge clk);
            check(op_err == 0, "R8", "error lasts one cycle", op_err, 0);
        end else if (e.noop) begin
            check(op_err == 0 && busy == 0 && tgt_req == 0, "R6", "no-op quiet",
                  {op_err, busy, tgt_req}, 0);
        end else begin
            run_step(tg, e.m0, e.c0, a);
            if (e.two) begin
                check(busy == 1 && tgt_req == 0, tg, "gap between steps",
                      {busy, tgt_req}, {1'b1, 5'b0});
                tgt_ack = 5'($urandom);
                @(negedge clk);
                tgt_ack = '0;
                run_step(tg, e.m1, e.c1, a);
            end
            check(busy == 0 && tgt_req == 0, "R10", "busy released after last ack",
                  {busy, tgt_req}, 0);
        end
    endtask

    initial begin
        int cyc = 0;
        while (!finished) begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
                $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'h1234_5678));
        repeat (3) @(negedge clk);
        check(tgt_req == 0 && busy == 0 && op_err == 0, "R10", "reset state",
              {tgt_req, busy, op_err}, 0);
        rst_n = 1;
        @(negedge clk);
        // directed: every listed encoding in both groups
        for (int t = 0; t < 2; t++)
            for (int o = 0; o < 8; o++)
                for (int c = 0; c < 16; c++)
                    do_op(t[0], o[2:0], c[3:0], $urandom);
        // directed back-to-back two-step and dual-target ops
        do_op(0, 1, 14, 32'hDEAD_BEEF);
        do_op(0, 2, 14, 32'h0000_00E0);
        do_op(0, 0, 7, 32'h1);
        do_op(1, 0, 7, 32'h2);
        do_op(0, 3, 3, 32'h3);
        // random mix
        for (int k = 0; k < 400; k++) begin
            if ($urandom_range(0, 1) == 0)
                do_op(1'($urandom), 3'($urandom_range(0, 4)), 4'($urandom), $urandom);
            else
                do_op(1'($urandom), 3'($urandom), 4'($urandom), $urandom);
            if ($urandom_range(0, 3) == 0) @(negedge clk);
        end
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule